// File: doc/BRIEF.md
# Interleaved Converter Output Latch

This block sits behind a bank of sixteen interleaved successive-approximation conversion sections. Each section samples the analog input in turn, one per clock, and hands over an 11-bit result in its transfer cycle. The block picks the section whose transfer slot is current, clamps the 11-bit result to a 10-bit straight-binary word plus an overrange flag, and latches both on the rising clock edge.

A rotating slot counter, cleared by reset, sets both the sampling order and the transfer order. A word leaves the output register a fixed twelve clocks after its section sampled. A data-available strobe marks each freshly latched word. It stays low until the pipeline has filled and a power-up calibration interval of at least 10,000 clocks has passed. An active-low enable controls a data-enable output, which stands in for the tri-state pad driver. While that output is low, the modelled bus reads zero.

Counting: edge k is the k-th rising clock edge with reset low, starting at k = 0. Section s samples at the edges where k mod 16 = s.

Top module: `adc_out_latch`

## Requirements
- R1: While reset is high, and after any edge at which reset was sampled high, `dout`, `ovr`, `dav` and `dout_en` are 0.
- R2: At edge k the block selects section (k − 12) mod 16, which is equivalently (k + 4) mod 16. Section s sits at bits [11s+10 : 11s] of `sec_word` and its strobe is `sec_xfer[s]`. If that strobe is high, the section's result is latched, so a sample taken at edge j is on the outputs after edge j + 12.
- R3: A selected result above 1023 (1024 to 2047) latches `ovr` = 1 and `dout` = 1023 (all ones).
- R4: A selected result of 0 to 1023 latches `ovr` = 0 and `dout` equal to the result in straight binary: 0 gives all zeros and 1023 gives all ones.
- R5: If the selected section's strobe is low at edge k, `dout` and `ovr` keep their previous values and `dav` is 0 after that edge.
- R6: Strobes and results of sections other than the selected one have no effect on `dout`, `ovr` or `dav`.
- R7: `dav` is 1 after edge k exactly when the selected strobe is high, k ≥ 12 and k ≥ 10,000. It is therefore a one-clock pulse for each latched word once the block is filled and calibrated.
- R8: The calibration count restarts from zero on every reset, so after a mid-run reset `dav` stays 0 for another 10,000 edges.
- R9: After each edge, `dout_en` equals the inverse of `oe_n` sampled at that edge. While `dout_en` is 0, `dout` reads 0 (high impedance). `ovr` is not gated by the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sec_word | input | 176 | Sixteen 11-bit section results, section s at bits [11s+10:11s] |
| sec_xfer | input | 16 | Per-section transfer strobes |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 10 | Latched straight-binary data word, reads 0 when disabled |
| dout_en | output | 1 | Bus drive enable (0 = high impedance) |
| ovr | output | 1 | Latched overrange flag |
| dav | output | 1 | Data-available strobe |

## Verification
The hardest state to reach is the moment calibration completes, because `dav` must first appear exactly at edge 10,000 and not one clock either side. The same boundary must be reached again after a reset in mid-stream. The stimulus runs the free-running stream straight through that edge twice, with random results and strobe drops on both sides of it. Directed phases place 0, 1023, 1024 and 2047 in the selected slot. They also raise every strobe except the selected one, and raise only the selected one, so that the slot arithmetic is exposed.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;
  localparam int unsigned SECTIONS_DEF  = 16;
  localparam int unsigned DATA_W_DEF    = 10;
  localparam int unsigned LATENCY_DEF   = 12;
  localparam int unsigned CAL_CYCLES_DEF = 10000;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_CAL  = 2'd1,
    ST_RUN  = 2'd2
  } out_phase_e;
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
  parameter int unsigned SECTIONS   = adc_out_pkg::SECTIONS_DEF,
  parameter int unsigned LATENCY    = adc_out_pkg::LATENCY_DEF,
  parameter int unsigned CAL_CYCLES = adc_out_pkg::CAL_CYCLES_DEF,
  localparam int unsigned SW        = $clog2(SECTIONS),
  localparam int unsigned FW        = $clog2(LATENCY + 1),
  localparam int unsigned CW        = $clog2(CAL_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] xfer_slot,
  output adc_out_pkg::out_phase_e phase
);
  localparam logic [SW-1:0] LAT_MOD = SW'(LATENCY % SECTIONS);
  localparam logic [FW-1:0] FILL_END = FW'(LATENCY);
  localparam logic [CW-1:0] CAL_END  = CW'(CAL_CYCLES);

  logic [SW-1:0] smp_slot_q;
  logic [FW-1:0] fill_q;
  logic [CW-1:0] cal_q;

  // sampling slot rotates every clock; transfer trails it by the latency
  always_ff @(posedge clk) begin
    if (rst) smp_slot_q <= '0;
    else     smp_slot_q <= smp_slot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  fill_q <= '0;
    else if (fill_q != FILL_END) fill_q <= fill_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cal_q <= '0;
    else if (cal_q != CAL_END) cal_q <= cal_q + 1'b1;
  end

  assign xfer_slot = smp_slot_q - LAT_MOD;

  always_comb begin
    if (fill_q != FILL_END)     phase = adc_out_pkg::ST_FILL;
    else if (cal_q != CAL_END)  phase = adc_out_pkg::ST_CAL;
    else                        phase = adc_out_pkg::ST_RUN;
  end
endmodule

// File: rtl/section_mux.sv
module section_mux #(
  parameter int unsigned SECTIONS = adc_out_pkg::SECTIONS_DEF,
  parameter int unsigned RES_W    = adc_out_pkg::DATA_W_DEF + 1,
  localparam int unsigned SW      = $clog2(SECTIONS)
) (
  input  logic [SECTIONS*RES_W-1:0] sec_word,
  input  logic [SECTIONS-1:0]       sec_xfer,
  input  logic [SW-1:0]             slot,
  output logic [RES_W-1:0]          word_sel,
  output logic                      xfer_sel
);
  logic [RES_W-1:0] lane [SECTIONS];

  for (genvar i = 0; i < SECTIONS; i++) begin : g_lane
    assign lane[i] = sec_word[i*RES_W +: RES_W];
  end

  assign word_sel = lane[slot];
  assign xfer_sel = sec_xfer[slot];
endmodule

// File: rtl/word_latch.sv
module word_latch #(
  parameter int unsigned DATA_W = adc_out_pkg::DATA_W_DEF,
  localparam int unsigned RES_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RES_W-1:0]  word_sel,
  input  logic              xfer_sel,
  input  adc_out_pkg::out_phase_e phase,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              ovr,
  output logic              dav
);
  logic              over;
  logic [DATA_W-1:0] clamped;
  logic [DATA_W-1:0] data_q;
  logic              ovr_q;
  logic              dav_q;
  logic              en_q;

  // top result bit set means the result is past full scale
  assign over    = word_sel[RES_W-1];
  assign clamped = over ? {DATA_W{1'b1}} : word_sel[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else if (xfer_sel) begin
      data_q <= clamped;
      ovr_q  <= over;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dav_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      dav_q <= xfer_sel && (phase == adc_out_pkg::ST_RUN);
      en_q  <= ~oe_n;
    end
  end

  assign dout    = en_q ? data_q : '0;
  assign dout_en = en_q;
  assign ovr     = ovr_q;
  assign dav     = dav_q;
endmodule

// File: rtl/adc_out_latch.sv
module adc_out_latch #(
  parameter int unsigned SECTIONS   = adc_out_pkg::SECTIONS_DEF,
  parameter int unsigned DATA_W     = adc_out_pkg::DATA_W_DEF,
  parameter int unsigned LATENCY    = adc_out_pkg::LATENCY_DEF,
  parameter int unsigned CAL_CYCLES = adc_out_pkg::CAL_CYCLES_DEF,
  localparam int unsigned RES_W     = DATA_W + 1,
  localparam int unsigned SW        = $clog2(SECTIONS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SECTIONS*RES_W-1:0] sec_word,
  input  logic [SECTIONS-1:0]       sec_xfer,
  input  logic                      oe_n,
  output logic [DATA_W-1:0]         dout,
  output logic                      dout_en,
  output logic                      ovr,
  output logic                      dav
);
  logic [SW-1:0]     xfer_slot;
  logic [RES_W-1:0]  word_sel;
  logic              xfer_sel;
  adc_out_pkg::out_phase_e phase;

  slot_sequencer #(
    .SECTIONS(SECTIONS), .LATENCY(LATENCY), .CAL_CYCLES(CAL_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .xfer_slot(xfer_slot), .phase(phase)
  );

  section_mux #(.SECTIONS(SECTIONS), .RES_W(RES_W)) u_mux (
    .sec_word(sec_word), .sec_xfer(sec_xfer), .slot(xfer_slot),
    .word_sel(word_sel), .xfer_sel(xfer_sel)
  );

  word_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .word_sel(word_sel), .xfer_sel(xfer_sel),
    .phase(phase), .oe_n(oe_n), .dout(dout), .dout_en(dout_en),
    .ovr(ovr), .dav(dav)
  );
endmodule

// File: rtl/adc_out_latch_chk.sv
module adc_out_latch_chk #(
  parameter int unsigned SECTIONS   = 16,
  parameter int unsigned DATA_W     = 10,
  parameter int unsigned LATENCY    = 12,
  parameter int unsigned CAL_CYCLES = 10000,
  localparam int unsigned RES_W     = DATA_W + 1,
  localparam int unsigned SW        = $clog2(SECTIONS),
  localparam int unsigned GW        = $clog2(CAL_CYCLES + LATENCY + 2)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [SECTIONS*RES_W-1:0] sec_word,
  input logic [SECTIONS-1:0]       sec_xfer,
  input logic                      oe_n,
  input logic [DATA_W-1:0]         dout,
  input logic                      dout_en,
  input logic                      ovr,
  input logic                      dav
);
  localparam int unsigned GATE = (CAL_CYCLES > LATENCY) ? CAL_CYCLES : LATENCY;
  logic [SW-1:0] k_q;
  logic [GW-1:0] age_q;
  logic [SW-1:0] sel_c;
  logic          miss_c;
  logic [RES_W-1:0] unused_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q   <= '0;
      age_q <= '0;
    end else begin
      k_q <= k_q + 1'b1;
      if (age_q != GW'(GATE)) age_q <= age_q + 1'b1;
    end
  end

  always_comb begin
    sel_c    = k_q - SW'(LATENCY % SECTIONS);
    miss_c   = !sec_xfer[sel_c];
    unused_c = sec_word[RES_W-1:0];
  end

  // R7: no data-available before fill and calibration
  p_dav_gate_r7: assert property (@(posedge clk) disable iff (rst)
    dav |-> (age_q == GW'(GATE)));

  // R5: missing strobe holds the word and drops dav
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    miss_c |=> ($stable(ovr) && !dav));

  // R3: overrange always comes with an all-ones word
  p_clamp_r3: assert property (@(posedge clk) disable iff (rst)
    (ovr && dout_en) |-> (dout == {DATA_W{1'b1}}));

  // R9: disabled bus reads zero
  p_hiz_r9: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0));

  // R9: enable follows the sampled input
  p_en_follow_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dout_en == !$past(oe_n)));
endmodule

bind adc_out_latch adc_out_latch_chk #(
  .SECTIONS(SECTIONS), .DATA_W(DATA_W), .LATENCY(LATENCY), .CAL_CYCLES(CAL_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .sec_word(sec_word), .sec_xfer(sec_xfer), .oe_n(oe_n),
  .dout(dout), .dout_en(dout_en), .ovr(ovr), .dav(dav)
);

// File: tb/tb_adc_out_latch.sv
`timescale 1ns/1ps
module tb_adc_out_latch;
  localparam int NS  = 16;
  localparam int DW  = 10;
  localparam int RW  = 11;
  localparam int CAL = 10000;
  localparam int LAT = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS*RW-1:0] sec_word = '0;
  logic [NS-1:0]   sec_xfer = '0;
  logic            oe_n = 1'b1;
  logic [DW-1:0]   dout;
  logic            dout_en, ovr, dav;

  int tests = 0;
  int fails = 0;
  int k = 0;
  bit done = 1'b0;
  logic [DW-1:0] e_word = '0;
  logic          e_ovr = 1'b0;
  logic          e_dav = 1'b0;
  logic          e_en  = 1'b0;

  adc_out_latch dut (
    .clk(clk), .rst(rst), .sec_word(sec_word), .sec_xfer(sec_xfer), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en), .ovr(ovr), .dav(dav)
  );

  always #2.5 clk = ~clk;

  function automatic logic [DW:0] clamp_ref(input logic [RW-1:0] w);
    if (w > 11'd1023) return {1'b1, 10'h3FF};
    return {1'b0, w[DW-1:0]};
  endfunction

  task automatic check_outputs(input string tag);
    logic [DW-1:0] xd;
    bit bad;
    xd = e_en ? e_word : '0;
    bad = 1'b0;
    tests++;
    if (dout !== xd) begin
      bad = 1'b1;
      $display("FAIL %s R2/R4 k=%0d dout=%0d expected %0d", tag, k, dout, xd);
    end
    if (ovr !== e_ovr) begin
      bad = 1'b1;
      $display("FAIL %s R3 k=%0d ovr=%0b expected %0b", tag, k, ovr, e_ovr);
    end
    if (dav !== e_dav) begin
      bad = 1'b1;
      $display("FAIL %s R7 k=%0d dav=%0b expected %0b", tag, k, dav, e_dav);
    end
    if (dout_en !== e_en) begin
      bad = 1'b1;
      $display("FAIL %s R9 k=%0d dout_en=%0b expected %0b", tag, k, dout_en, e_en);
    end
    if (bad) fails++;
  endtask

  // mode 0 random, 1 only selected strobe, 2 all but selected, 3 directed corner words
  task automatic step(input int mode, input string tag);
    int sel;
    logic [DW:0] c;
    sel = (k + 4) % NS;
    for (int i = 0; i < NS; i++) begin
      sec_word[i*RW +: RW] = RW'($urandom % 2048);
    end
    case (mode)
      1: sec_xfer = NS'(1) << sel;
      2: sec_xfer = ~(NS'(1) << sel);
      3: begin
        sec_xfer = '1;
        case (k % 4)
          0: sec_word[sel*RW +: RW] = 11'd0;
          1: sec_word[sel*RW +: RW] = 11'd1023;
          2: sec_word[sel*RW +: RW] = 11'd1024;
          default: sec_word[sel*RW +: RW] = 11'd2047;
        endcase
      end
      default: sec_xfer = NS'($urandom) | NS'($urandom);
    endcase
    oe_n = ($urandom % 8) == 0;
    if (sec_xfer[sel]) begin
      c = clamp_ref(sec_word[sel*RW +: RW]);
      e_word = c[DW-1:0];
      e_ovr  = c[DW];
    end
    e_dav = sec_xfer[sel] && (k >= LAT) && (k >= CAL);
    e_en  = !oe_n;
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag);
    k++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    e_word = '0; e_ovr = 1'b0; e_dav = 1'b0; e_en = 1'b0;
    check_outputs("R1 reset");
    rst = 1'b0;
    k = 0;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired at k=%0d", k);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 40; i++) step(3, "R3/R4 corner words");
    for (int i = 0; i < 40; i++) step(i % 2 + 1, "R5/R6 strobe isolation");
    while (k < CAL - 20) step(0, "R2 random stream");
    while (k < CAL + 200) step(k % 5 == 0 ? 2 : 0, "R7 calibration edge");
    for (int i = 0; i < 32; i++) step(3, "R3 corner words calibrated");
    do_reset();
    while (k < CAL - 5) step(k % 7 == 0 ? 1 : 0, "R8 recalibration");
    while (k < CAL + 60) step(0, "R8 calibration after reset");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule